// File: doc/BRIEF.md
# Channelized Port Timeslot Mapper

This block sits on one serial port that carries a single framed T1 or E1 bit stream. It maps every 8-bit DS0 timeslot of that stream onto one of 256 logical HDLC channels, or marks the slot unused. Each slot can carry either a full 64 kbps, where all eight bits go to the channel, or 56 kbps, where the least significant bit is dropped. Several slots may name the same channel, which builds an N x 64 or N x 56 kbps pipe. A mode bit can turn the slot mapping off. In that mode the whole stream goes to one channel.

Each slot has its own two-bit loop code. A line loop sends the bits received in a slot back out on the transmit line in the same slot. A local loop feeds the bits the HDLC side transmitted in a slot back into the receive path. In unchannelized mode one loop code covers the whole stream. The receive and transmit sides each have their own bit strobe and frame sync, sampled in the block clock domain. Received bits leave as a valid pulse tagged with the channel number. Transmit bits are requested from the HDLC engines through a request that is tagged the same way.

The slot table is written through a simple write port into a shadow copy. Each direction loads the shadow copy at its own next frame start, so a frame is never processed with a half-updated table.

Top module: `tsm_port_mapper`

## Requirements
- R1: After reset, `rx_vld` and `tx_req` are 0, `tx_line` is 1 and every slot of the table is disabled.
- R2: In E1 mode (`cfg_t1`=0), frame position p, counted from 0 at frame start, is slot p/8 and bit p%8. The bit with index 7 is the last bit of the slot and its LSB. For an enabled 64k slot, each strobed receive bit appears on `rx_bit` with `rx_chan` and a one-cycle `rx_vld` pulse in the cycle after the strobe. A frame wraps to position 0 after 256 bits even without a sync.
- R3: In channelized T1 mode (`cfg_t1`=1), the first bit of a frame is a framing bit. It produces no `rx_vld` and no `tx_req`, and `tx_line` is driven to 1 for it. Slots 0 to 23 follow, and the frame wraps after 193 bits.
- R4: For a slot with the 56k flag, receive bit 7 produces no `rx_vld`. Transmit bit 7 raises no `tx_req`, and the line is driven to 1.
- R5: A disabled slot produces no `rx_vld` and no `tx_req`, and its transmit bits are 1. Its loop code is ignored.
- R6: For an enabled, unlooped slot bit, `tx_req` is high with `tx_req_chan` during the strobe cycle. `tx_line` takes `tx_hdlc_bit` at that strobe and holds it until the next strobe.
- R7: With loop code bit 0 set (codes 1 and 3) on an enabled slot, the transmit line carries the bits last received in the same slot and bit positions, and raises no `tx_req`.
- R8: With loop code bit 1 set (codes 2 and 3) on an enabled slot, `rx_bit` carries the bit last transmitted at the same slot and bit position, instead of `rx_data`. A bit for which no request was made counts as transmitted 1.
- R9: With `cfg_unch`=1, frames are 256 bits with no framing bit, whatever `cfg_t1` is. Every bit goes to the channel number of table entry 0. `cfg_unch_lb` applies the loop codes of R7 and R8 to the whole stream.
- R10: A frame sync seen with a strobe forces that bit to frame position 0.
- R11: Table writes and mode inputs take effect in a direction only from that direction's next frame start. The bit at position 0 already uses the new settings.
- Table entry encoding on `cfg_wdata`: [11] enable, [10] 56k, [9:8] loop code, [7:0] channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Slot table write strobe |
| cfg_addr | input | 5 | Slot number to write |
| cfg_wdata | input | 12 | Slot entry: enable, 56k, loop code, channel |
| cfg_t1 | input | 1 | 1 selects T1 framing, 0 selects E1 |
| cfg_unch | input | 1 | 1 selects unchannelized operation |
| cfg_unch_lb | input | 2 | Loop code for the whole stream when unchannelized |
| rx_stb | input | 1 | Receive bit strobe |
| rx_fsync | input | 1 | Receive frame sync, qualified by `rx_stb` |
| rx_data | input | 1 | Receive line bit |
| rx_vld | output | 1 | Receive bit valid toward the HDLC engines |
| rx_chan | output | 8 | Channel of the receive bit |
| rx_bit | output | 1 | Receive bit value |
| tx_stb | input | 1 | Transmit bit strobe |
| tx_fsync | input | 1 | Transmit frame sync, qualified by `tx_stb` |
| tx_hdlc_bit | input | 1 | Transmit bit returned by the engine of `tx_req_chan` |
| tx_req | output | 1 | Transmit bit request, same cycle as the strobe |
| tx_req_chan | output | 8 | Channel asked for a transmit bit |
| tx_line | output | 1 | Transmit line bit |

## Verification
The hardest case to reach from the ports is a loopback slot whose output depends on what the other direction carried in that slot a whole frame earlier. The same is true when such a loopback meets a table write that lands in the middle of a frame and must wait for the next frame start. The stimulus runs receive and transmit frames back to back, aligned on the same syncs, with data from an LFSR. A running model from the requirements keeps the last bits seen per slot position in each direction. It also keeps the shadow and active tables apart, so every bit of the second and later frames has a known expected value. Writes are placed mid-frame, a sync is forced in the middle of a T1 frame, and frames are left to wrap without a sync.

// File: rtl/tsm_pkg.sv
package tsm_pkg;

    localparam int SLOTS      = 32;
    localparam int SLOT_BITS  = 8;
    localparam int CHAN_W     = 8;
    localparam int T1_SLOTS   = 24;
    localparam int SLOT_W     = $clog2(SLOTS);
    localparam int BIT_W      = $clog2(SLOT_BITS);
    localparam int IDX_W      = SLOT_W + BIT_W;
    localparam int FRAME_BITS = SLOTS * SLOT_BITS;
    localparam int POS_W      = $clog2(FRAME_BITS + 1);
    localparam int ENTRY_W    = CHAN_W + 4;

    typedef enum logic [1:0] {
        LB_OFF   = 2'd0,
        LB_LINE  = 2'd1,
        LB_LOCAL = 2'd2,
        LB_BOTH  = 2'd3
    } tsm_lb_e;

    typedef struct packed {
        logic              en;
        logic              r56;
        tsm_lb_e           lb;
        logic [CHAN_W-1:0] chan;
    } tsm_slot_t;

    typedef struct packed {
        logic    t1;
        logic    unch;
        tsm_lb_e unch_lb;
    } tsm_mode_t;

    typedef struct packed {
        logic              fbit;
        logic [SLOT_W-1:0] slot;
        logic [BIT_W-1:0]  bitn;
    } tsm_pos_t;

    function automatic logic framed_t1(tsm_mode_t m);
        return m.t1 && !m.unch;
    endfunction

    function automatic logic [POS_W-1:0] last_pos(tsm_mode_t m);
        return framed_t1(m) ? POS_W'(T1_SLOTS * SLOT_BITS) : POS_W'(FRAME_BITS - 1);
    endfunction

    function automatic tsm_pos_t decode_pos(logic [POS_W-1:0] p, tsm_mode_t m);
        tsm_pos_t         d;
        logic [IDX_W-1:0] q;
        q      = framed_t1(m) ? IDX_W'(p - POS_W'(1)) : IDX_W'(p);
        d.fbit = framed_t1(m) && (p == '0);
        d.slot = q[IDX_W-1:BIT_W];
        d.bitn = q[BIT_W-1:0];
        return d;
    endfunction

    function automatic logic lsb_bit(tsm_pos_t d);
        return d.bitn == BIT_W'(SLOT_BITS - 1);
    endfunction

    function automatic logic has_line(tsm_lb_e lb);
        return (lb == LB_LINE) || (lb == LB_BOTH);
    endfunction

    function automatic logic has_local(tsm_lb_e lb);
        return (lb == LB_LOCAL) || (lb == LB_BOTH);
    endfunction

endpackage

// File: rtl/tsm_frame_pos.sv
module tsm_frame_pos
    import tsm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             stb,
    input  logic             fsync,
    input  tsm_mode_t        mode_in,
    output logic [POS_W-1:0] cur_pos,
    output logic             fstart,
    output tsm_mode_t        mode_eff
);

    logic [POS_W-1:0] pos_q;
    tsm_mode_t        mode_q;

    always_comb begin
        cur_pos  = fsync ? '0 : pos_q;
        fstart   = stb && (cur_pos == '0);
        mode_eff = fstart ? mode_in : mode_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q  <= '0;
            mode_q <= '0;
        end else if (stb) begin
            pos_q <= (cur_pos == last_pos(mode_eff)) ? '0 : cur_pos + POS_W'(1);
            if (fstart) begin
                mode_q <= mode_in;
            end
        end
    end

    // R3: a T1 frame never counts beyond its 193rd bit
    a_r3_t1_bound: assert property (@(posedge clk) disable iff (rst)
        framed_t1(mode_q) |-> (pos_q <= POS_W'(T1_SLOTS * SLOT_BITS)));

    // R10: a sync restarts the frame, so the next bit is position 1
    a_r10_sync_restart: assert property (@(posedge clk) disable iff (rst)
        (stb && fsync) |=> (pos_q == POS_W'(1)));

endmodule

// File: rtl/tsm_slot_table.sv
module tsm_slot_table
    import tsm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_addr,
    input  tsm_slot_t         wr_entry,
    input  logic              commit_rx,
    input  logic              commit_tx,
    input  logic [SLOT_W-1:0] rx_idx,
    input  logic [SLOT_W-1:0] tx_idx,
    output tsm_slot_t         rx_entry,
    output tsm_slot_t         tx_entry
);

    tsm_slot_t shadow [SLOTS];
    tsm_slot_t act_rx [SLOTS];
    tsm_slot_t act_tx [SLOTS];

    always_ff @(posedge clk) begin
        for (int i = 0; i < SLOTS; i++) begin
            if (rst) begin
                shadow[i] <= '0;
                act_rx[i] <= '0;
                act_tx[i] <= '0;
            end else begin
                if (wr_en && (wr_addr == SLOT_W'(i))) begin
                    shadow[i] <= wr_entry;
                end
                if (commit_rx) begin
                    act_rx[i] <= shadow[i];
                end
                if (commit_tx) begin
                    act_tx[i] <= shadow[i];
                end
            end
        end
    end

    // the bit at a frame start already sees the freshly loaded entry
    always_comb begin
        rx_entry = commit_rx ? shadow[rx_idx] : act_rx[rx_idx];
        tx_entry = commit_tx ? shadow[tx_idx] : act_tx[tx_idx];
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_chk
        // R11: active entries move only at a frame start of their direction
        a_r11_rx_hold: assert property (@(posedge clk) disable iff (rst)
            !commit_rx |=> $stable(act_rx[g]));
        a_r11_tx_hold: assert property (@(posedge clk) disable iff (rst)
            !commit_tx |=> $stable(act_tx[g]));
    end

endmodule

// File: rtl/tsm_rx_lane.sv
module tsm_rx_lane
    import tsm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              stb,
    input  logic              data,
    input  tsm_pos_t          pos,
    input  logic              unch,
    input  tsm_lb_e           unch_lb,
    input  tsm_slot_t         entry,
    input  logic              loop_bit,
    output logic [IDX_W-1:0]  idx,
    input  logic [IDX_W-1:0]  peer_idx,
    output logic              peer_bit,
    output logic              vld,
    output logic [CHAN_W-1:0] chan,
    output logic              data_o
);

    logic [FRAME_BITS-1:0] hold;
    tsm_lb_e               lb;
    logic                  active;
    logic                  used;
    logic                  sel;

    always_comb begin
        lb       = unch ? unch_lb : entry.lb;
        active   = unch || entry.en;
        used     = !pos.fbit && (unch || (entry.en && !(entry.r56 && lsb_bit(pos))));
        sel      = (active && has_local(lb)) ? loop_bit : data;
        idx      = {pos.slot, pos.bitn};
        peer_bit = hold[peer_idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld    <= 1'b0;
            chan   <= '0;
            data_o <= 1'b0;
            hold   <= '0;
        end else begin
            vld <= stb && used;
            if (stb && used) begin
                chan   <= entry.chan;
                data_o <= sel;
            end
            if (stb && !pos.fbit) begin
                hold[idx] <= data;
            end
        end
    end

    // R3: the framing bit never reaches a channel
    a_r3_fbit_silent: assert property (@(posedge clk) disable iff (rst)
        (stb && pos.fbit) |=> !vld);

    // R4: the LSB of a 56k slot is dropped on receive
    a_r4_lsb_dropped: assert property (@(posedge clk) disable iff (rst)
        (stb && !unch && entry.r56 && lsb_bit(pos)) |=> !vld);

    // R5: disabled slots stay silent
    a_r5_rx_disabled: assert property (@(posedge clk) disable iff (rst)
        (stb && !unch && !entry.en) |=> !vld);

    // R9: unchannelized mode forwards every bit
    a_r9_unch_every_bit: assert property (@(posedge clk) disable iff (rst)
        (stb && unch) |=> vld);

    // R2: a valid pulse always follows a strobe
    a_r2_vld_after_stb: assert property (@(posedge clk) disable iff (rst)
        vld |-> $past(stb));

endmodule

// File: rtl/tsm_tx_lane.sv
module tsm_tx_lane
    import tsm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              stb,
    input  tsm_pos_t          pos,
    input  logic              unch,
    input  tsm_lb_e           unch_lb,
    input  tsm_slot_t         entry,
    input  logic              hdlc_bit,
    input  logic              loop_bit,
    output logic [IDX_W-1:0]  idx,
    input  logic [IDX_W-1:0]  peer_idx,
    output logic              peer_bit,
    output logic              req,
    output logic [CHAN_W-1:0] req_chan,
    output logic              line
);

    logic [FRAME_BITS-1:0] hold;
    tsm_lb_e               lb;
    logic                  active;
    logic                  line_loop;
    logic                  send;
    logic                  nxt_line;

    always_comb begin
        lb        = unch ? unch_lb : entry.lb;
        active    = unch || entry.en;
        line_loop = active && has_line(lb);
        send      = !pos.fbit && active && !line_loop &&
                    (unch || !(entry.r56 && lsb_bit(pos)));
        req       = stb && send;
        req_chan  = entry.chan;
        idx       = {pos.slot, pos.bitn};
        peer_bit  = hold[peer_idx];
        if (pos.fbit) begin
            nxt_line = 1'b1;
        end else if (line_loop) begin
            nxt_line = loop_bit;
        end else if (send) begin
            nxt_line = hdlc_bit;
        end else begin
            nxt_line = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line <= 1'b1;
            hold <= '0;
        end else if (stb) begin
            line <= nxt_line;
            if (!pos.fbit) begin
                hold[idx] <= send ? hdlc_bit : 1'b1;
            end
        end
    end

    // R6: the line only moves on a strobe
    a_r6_line_holds: assert property (@(posedge clk) disable iff (rst)
        !stb |=> $stable(line));

    // R4: the LSB of an unlooped 56k slot goes out as 1
    a_r4_tx_lsb_one: assert property (@(posedge clk) disable iff (rst)
        (stb && !unch && entry.en && entry.r56 && !has_line(entry.lb) &&
         lsb_bit(pos) && !pos.fbit) |=> line);

    // R5: a disabled slot idles at 1
    a_r5_tx_disabled: assert property (@(posedge clk) disable iff (rst)
        (stb && !unch && !entry.en) |=> line);

    // R3: the framing bit goes out as 1
    a_r3_tx_fbit: assert property (@(posedge clk) disable iff (rst)
        (stb && pos.fbit) |=> line);

endmodule

// File: rtl/tsm_port_mapper.sv
module tsm_port_mapper
    import tsm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [SLOT_W-1:0]  cfg_addr,
    input  logic [ENTRY_W-1:0] cfg_wdata,
    input  logic               cfg_t1,
    input  logic               cfg_unch,
    input  logic [1:0]         cfg_unch_lb,
    input  logic               rx_stb,
    input  logic               rx_fsync,
    input  logic               rx_data,
    output logic               rx_vld,
    output logic [CHAN_W-1:0]  rx_chan,
    output logic               rx_bit,
    input  logic               tx_stb,
    input  logic               tx_fsync,
    input  logic               tx_hdlc_bit,
    output logic               tx_req,
    output logic [CHAN_W-1:0]  tx_req_chan,
    output logic               tx_line
);

    tsm_mode_t         mode_in;
    tsm_mode_t         rx_mode;
    tsm_mode_t         tx_mode;
    logic [POS_W-1:0]  rx_cur;
    logic [POS_W-1:0]  tx_cur;
    logic              rx_fstart;
    logic              tx_fstart;
    tsm_pos_t          rx_pos;
    tsm_pos_t          tx_pos;
    logic [SLOT_W-1:0] rx_tab_idx;
    logic [SLOT_W-1:0] tx_tab_idx;
    tsm_slot_t         rx_entry;
    tsm_slot_t         tx_entry;
    logic [IDX_W-1:0]  rx_idx;
    logic [IDX_W-1:0]  tx_idx;
    logic              rx_peer_bit;
    logic              tx_peer_bit;

    always_comb begin
        mode_in.t1      = cfg_t1;
        mode_in.unch    = cfg_unch;
        mode_in.unch_lb = tsm_lb_e'(cfg_unch_lb);
        rx_pos          = decode_pos(rx_cur, rx_mode);
        tx_pos          = decode_pos(tx_cur, tx_mode);
        rx_tab_idx      = rx_mode.unch ? '0 : rx_pos.slot;
        tx_tab_idx      = tx_mode.unch ? '0 : tx_pos.slot;
    end

    tsm_frame_pos i_rx_pos (
        .clk      (clk),
        .rst      (rst),
        .stb      (rx_stb),
        .fsync    (rx_fsync),
        .mode_in  (mode_in),
        .cur_pos  (rx_cur),
        .fstart   (rx_fstart),
        .mode_eff (rx_mode)
    );

    tsm_frame_pos i_tx_pos (
        .clk      (clk),
        .rst      (rst),
        .stb      (tx_stb),
        .fsync    (tx_fsync),
        .mode_in  (mode_in),
        .cur_pos  (tx_cur),
        .fstart   (tx_fstart),
        .mode_eff (tx_mode)
    );

    tsm_slot_table i_table (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (cfg_we),
        .wr_addr   (cfg_addr),
        .wr_entry  (tsm_slot_t'(cfg_wdata)),
        .commit_rx (rx_fstart),
        .commit_tx (tx_fstart),
        .rx_idx    (rx_tab_idx),
        .tx_idx    (tx_tab_idx),
        .rx_entry  (rx_entry),
        .tx_entry  (tx_entry)
    );

    tsm_rx_lane i_rx (
        .clk      (clk),
        .rst      (rst),
        .stb      (rx_stb),
        .data     (rx_data),
        .pos      (rx_pos),
        .unch     (rx_mode.unch),
        .unch_lb  (rx_mode.unch_lb),
        .entry    (rx_entry),
        .loop_bit (tx_peer_bit),
        .idx      (rx_idx),
        .peer_idx (tx_idx),
        .peer_bit (rx_peer_bit),
        .vld      (rx_vld),
        .chan     (rx_chan),
        .data_o   (rx_bit)
    );

    tsm_tx_lane i_tx (
        .clk      (clk),
        .rst      (rst),
        .stb      (tx_stb),
        .pos      (tx_pos),
        .unch     (tx_mode.unch),
        .unch_lb  (tx_mode.unch_lb),
        .entry    (tx_entry),
        .hdlc_bit (tx_hdlc_bit),
        .loop_bit (rx_peer_bit),
        .idx      (tx_idx),
        .peer_idx (rx_idx),
        .peer_bit (tx_peer_bit),
        .req      (tx_req),
        .req_chan (tx_req_chan),
        .line     (tx_line)
    );

endmodule

// File: tb/test_tsm_port_mapper.sv
`timescale 1ns/1ps
module test_tsm_port_mapper;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [4:0] cfg_addr = '0;
    logic [11:0] cfg_wdata = '0;
    logic       cfg_t1 = 1'b0;
    logic       cfg_unch = 1'b0;
    logic [1:0] cfg_unch_lb = 2'd0;
    logic       rx_stb = 1'b0;
    logic       rx_fsync = 1'b0;
    logic       rx_data = 1'b0;
    logic       rx_vld;
    logic [7:0] rx_chan;
    logic       rx_bit;
    logic       tx_stb = 1'b0;
    logic       tx_fsync = 1'b0;
    logic       tx_hdlc_bit = 1'b0;
    logic       tx_req;
    logic [7:0] tx_req_chan;
    logic       tx_line;

    always #4 clk = ~clk;

    tsm_port_mapper i_tsm_port_mapper (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_t1(cfg_t1), .cfg_unch(cfg_unch),
        .cfg_unch_lb(cfg_unch_lb), .rx_stb(rx_stb), .rx_fsync(rx_fsync),
        .rx_data(rx_data), .rx_vld(rx_vld), .rx_chan(rx_chan), .rx_bit(rx_bit),
        .tx_stb(tx_stb), .tx_fsync(tx_fsync), .tx_hdlc_bit(tx_hdlc_bit),
        .tx_req(tx_req), .tx_req_chan(tx_req_chan), .tx_line(tx_line)
    );

    // slot, entry {en, 56k, loop[1:0], chan[7:0]}
    localparam int NVEC = 10;
    localparam logic [16:0] VEC [NVEC] = '{
        {5'd0,  12'h811}, {5'd1,  12'hC22}, {5'd2,  12'h933}, {5'd3,  12'hA44},
        {5'd5,  12'h355}, {5'd7,  12'hE77}, {5'd12, 12'h811}, {5'd23, 12'h899},
        {5'd24, 12'h8AA}, {5'd31, 12'hFBB}
    };

    int checks = 0;
    int failures = 0;
    string scen = "";

    // reference state from the requirements
    logic [11:0] m_sh  [32];
    logic [11:0] m_act [32];
    logic        m_rxh [256];
    logic        m_txh [256];
    int          m_pos = 0;
    logic        m_t1 = 1'b0, m_unch = 1'b0;
    logic [1:0]  m_ulb = 2'd0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input int a, input logic [11:0] d);
        cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        m_sh[a] = d;
    endtask

    task automatic step(input logic fs, input logic we, input int wa, input logic [11:0] wd);
        logic rd, hb, fb, en, r56, act_on, ev, eb, lloop, send, el;
        logic [11:0] e;
        logic [1:0] lb;
        logic [7:0] ch;
        int cp, q, slot, b, idx, last;
        string tg, tt;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        rd = lfsr[0]; hb = lfsr[5];
        rx_stb = 1'b1; tx_stb = 1'b1; rx_fsync = fs; tx_fsync = fs;
        rx_data = rd; tx_hdlc_bit = hb;
        cfg_we = we; cfg_addr = 5'(wa); cfg_wdata = wd;
        cp = fs ? 0 : m_pos;
        if (cp == 0) begin
            for (int i = 0; i < 32; i++) m_act[i] = m_sh[i];
            m_t1 = cfg_t1; m_unch = cfg_unch; m_ulb = cfg_unch_lb;
        end
        if (we) m_sh[wa] = wd;
        fb = m_t1 && !m_unch && (cp == 0);
        q = (m_t1 && !m_unch) ? cp - 1 : cp;
        if (fb) q = 0;
        slot = q / 8; b = q % 8; idx = slot * 8 + b;
        e = m_unch ? m_act[0] : m_act[slot];
        en = e[11]; r56 = e[10]; ch = e[7:0];
        lb = m_unch ? m_ulb : e[9:8];
        act_on = m_unch || en;
        ev = !fb && (m_unch || (en && !(r56 && b == 7)));
        eb = (act_on && lb[1]) ? m_txh[idx] : rd;
        lloop = act_on && lb[0];
        send = !fb && act_on && !lloop && (m_unch || !(r56 && b == 7));
        el = fb ? 1'b1 : (lloop ? m_rxh[idx] : (send ? hb : 1'b1));
        if (fb) tg = "R3";
        else if (m_unch) tg = "R9";
        else if (!en) tg = "R5";
        else if (lb[0]) tg = "R7";
        else if (lb[1]) tg = "R8";
        else if (r56 && b == 7) tg = "R4";
        else tg = "R2";
        tt = (tg == "R2") ? "R6" : tg;
        if (scen != "") begin tg = {scen, "/", tg}; tt = {scen, "/", tt}; end
        last = (m_t1 && !m_unch) ? 192 : 255;
        m_pos = (cp == last) ? 0 : cp + 1;
        #1;
        chk(tx_req == send, tt, $sformatf("tx_req pos %0d", cp), tx_req, send);
        if (send) chk(tx_req_chan == ch, tt, "tx_req_chan", tx_req_chan, ch);
        @(negedge clk);
        chk(rx_vld == ev, tg, $sformatf("rx_vld pos %0d", cp), rx_vld, ev);
        if (ev) begin
            chk(rx_chan == ch, tg, "rx_chan", rx_chan, ch);
            chk(rx_bit == eb, tg, $sformatf("rx_bit pos %0d", cp), rx_bit, eb);
        end
        chk(tx_line == el, tt, $sformatf("tx_line pos %0d", cp), tx_line, el);
        if (!fb) begin
            m_rxh[idx] = rd;
            m_txh[idx] = send ? hb : 1'b1;
        end
        rx_stb = 1'b0; tx_stb = 1'b0; rx_fsync = 1'b0; tx_fsync = 1'b0; cfg_we = 1'b0;
    endtask

    task automatic run(input int n, input logic fs_first);
        for (int i = 0; i < n; i++) step(fs_first && (i == 0), 1'b0, 0, 12'h000);
    endtask

    task automatic idle(input int n);
        logic held;
        held = tx_line;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(rx_vld == 1'b0, "R2", "rx_vld idle", rx_vld, 0);
            chk(tx_req == 1'b0, "R6", "tx_req idle", tx_req, 0);
            chk(tx_line == held, "R6", "tx_line hold", tx_line, held);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) begin m_sh[i] = '0; m_act[i] = '0; end
        for (int i = 0; i < 256; i++) begin m_rxh[i] = 1'b0; m_txh[i] = 1'b0; end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(rx_vld == 1'b0, "R1", "rx_vld", rx_vld, 0);
        chk(tx_req == 1'b0, "R1", "tx_req", tx_req, 0);
        chk(tx_line == 1'b1, "R1", "tx_line", tx_line, 1);

        // R1: empty table, one E1 frame with nothing enabled
        scen = "R1";
        run(256, 1'b1);

        // table vectors, then E1 frames; the second wraps without a sync
        for (int v = 0; v < NVEC; v++) cfg_write(int'(VEC[v][16:12]), VEC[v][11:0]);
        scen = "";
        run(256, 1'b1);
        run(256, 1'b0);
        idle(5);

        // R11: writes mid-frame wait for the next frame start
        scen = "R11";
        for (int i = 0; i < 256; i++) begin
            if (i == 100) step(1'b0, 1'b1, 20, 12'h8CC);
            else if (i == 140) step(1'b0, 1'b1, 0, 12'h8DD);
            else step(i == 0, 1'b0, 0, 12'h000);
        end
        run(256, 1'b0);

        // R3: T1 framing, second frame wraps after 193 bits
        scen = "R3";
        cfg_t1 = 1'b1;
        run(193, 1'b1);
        run(193, 1'b0);

        // R10: sync forced in the middle of a T1 frame
        scen = "R10";
        run(60, 1'b0);
        run(193, 1'b1);

        // R9: unchannelized with each loop code
        scen = "R9";
        cfg_unch = 1'b1; cfg_unch_lb = 2'd0;
        run(256, 1'b1);
        cfg_unch_lb = 2'd3;
        run(256, 1'b1);
        run(256, 1'b1);
        cfg_unch_lb = 2'd2;
        run(256, 1'b1);
        cfg_unch_lb = 2'd1;
        run(256, 1'b0);

        // back to channelized E1
        scen = "";
        cfg_unch = 1'b0; cfg_unch_lb = 2'd0; cfg_t1 = 1'b0;
        run(256, 1'b1);
        idle(3);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule